// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block holds the in-flight loads of an out-of-order core in a circular ring. Loads enter in program order at the tail, each tagged with a sequence number. They leave from the head when commit reports the youngest retired sequence number, or from the tail when a squash cancels everything younger than a given number. Each allocation hands back the ring slot the load now occupies. It also returns a store-queue reference: the current store-queue tail, or an all-ones invalid marker when the store queue is empty.

When a load executes, its address is written into its slot. When a store executes, it presents the load-ring index it recorded at its own allocation together with its address. A scanner then walks the ring from that index towards the tail, one slot per cycle, looking for an executed load whose coarse address (the address shifted right by a parameter number of bits) equals the store's. The first such load is a younger load that ran ahead of an older store. Its slot and sequence number are latched as a pending violation, which stays until it is read. While a violation is pending, store checks are skipped. A single blocked-load record is also kept, and a squash older than that load clears it.

Top module: `lq_order_unit`

## Requirements
- R1: The ring has DEPTH+1 slots and holds at most DEPTH loads. `full` is high when `count` equals DEPTH. `alloc_lq_idx` shows the tail slot a new load takes. The tail steps by one per accepted allocation and wraps from slot DEPTH to slot 0.
- R2: An allocation while full changes nothing. The cycle after it, `err_full` is high for one cycle.
- R3: A commit frees, in one cycle, every consecutive entry from the head whose sequence number is less than or equal to `commit_seq` (unsigned compare). It stops at the first younger entry.
- R4: A commit while the ring is empty changes nothing. The cycle after it, `err_empty` is high for one cycle.
- R5: A squash removes, in one cycle, consecutive entries backwards from tail-1 whose sequence number is greater than `squash_seq`. It stops at the first entry that is older or equal. The tail moves back, so the next allocation reuses the first removed slot.
- R6: In a cycle with `squash_valid` high, an allocation or commit request is ignored and raises no error flag.
- R7: `alloc_sq_ref` equals `{1'b0, alloc_sq_tail}` when `alloc_sq_empty` is low. It equals all ones (the invalid marker) when `alloc_sq_empty` is high.
- R8: A store check is accepted when `chk_busy` is low. It examines slots from `chk_lq_idx` up to (excluding) the tail, one per cycle. It stops at the first executed load whose address shifted right by SHIFT equals the store address shifted right by SHIFT. A hit at offset j reports `chk_done` with `chk_hit`=1 and `chk_hit_idx` j+1 cycles after acceptance. Reaching the tail at offset d reports `chk_done` with `chk_hit`=0 after d+1 cycles.
- R9: A load whose slot received no address update since its allocation never matches, whatever value the slot's address holds.
- R10: A hit sets `viol_pending` and latches the slot (`viol_idx`) and its sequence number (`viol_seq`). These hold until `viol_read` is pulsed, which clears `viol_pending` in the next cycle.
- R11: A check accepted while `viol_pending` is high scans nothing. It reports `chk_done` with `chk_hit`=0 one cycle after acceptance and leaves the pending violation unchanged.
- R12: `blk_set` records a blocked load with sequence number `blk_seq` and raises `blocked`. A squash with `squash_seq` lower than that number clears `blocked`; a squash with an equal or higher number leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tail | input | SQ_IDX_W | Current store-queue tail |
| alloc_sq_empty | input | 1 | Store queue holds no entries |
| alloc_lq_idx | output | IDX_W | Slot given to the new load |
| alloc_sq_ref | output | SQ_IDX_W+1 | Store-queue reference recorded for the load |
| upd_valid | input | 1 | Write an executed load's address |
| upd_idx | input | IDX_W | Slot of the executed load |
| upd_addr | input | ADDR_W | Address of the executed load |
| chk_valid | input | 1 | Start a store ordering check |
| chk_lq_idx | input | IDX_W | Load slot recorded by the store |
| chk_addr | input | ADDR_W | Store address |
| chk_busy | output | 1 | Scanner occupied |
| chk_done | output | 1 | One-cycle end-of-check pulse |
| chk_hit | output | 1 | Check found an overlapping younger load |
| chk_hit_idx | output | IDX_W | Slot of that load |
| commit_valid | input | 1 | Retire loads |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Cancel younger loads |
| squash_seq | input | SEQ_W | Squash boundary sequence number |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| blocked | output | 1 | Blocked-load record valid |
| viol_pending | output | 1 | Unread ordering violation held |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_read | input | 1 | Read and clear the violation |
| count | output | CNT_W | Live entries |
| full | output | 1 | Ring at capacity |
| err_full | output | 1 | Allocation was rejected last cycle |
| err_empty | output | 1 | Commit on an empty ring last cycle |

## Verification
Squash is swept over every boundary between, below and above a four-entry ring of evenly spaced sequence numbers. This separates a walk that stops at the first older entry from one that removes too many or too few. The ordering check is swept over every start offset in the live window, crossed with store addresses chosen to hit two loads in the same coarse block, one distinct block, no block at all, and a block that only a stale, unexecuted slot holds. The latency count shows whether the scan stops at the first hit or at the tail, and the stale case shows whether unexecuted loads are excluded. Allocation and commit are driven across wrap, full, empty and squash collisions, and checks issued with an unread violation tell the skip path from a real scan.

// File: rtl/lq_pkg.sv
package lq_pkg;

   typedef enum logic [1:0] {
      SCAN_IDLE = 2'd0,
      SCAN_WALK = 2'd1,
      SCAN_SKIP = 2'd2
   } scan_state_e;

   // modular index arithmetic for a ring of n slots
   function automatic int unsigned ring_add(input int unsigned a, input int unsigned b,
                                            input int unsigned n);
      return (a + b) % n;
   endfunction

   function automatic int unsigned ring_sub(input int unsigned a, input int unsigned b,
                                            input int unsigned n);
      return (a + n - (b % n)) % n;
   endfunction

endpackage

// File: rtl/lq_ring_ctrl.sv
module lq_ring_ctrl
   import lq_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int SEQ_W = 8,
   parameter int SLOTS = DEPTH + 1,
   parameter int IDX_W = $clog2(SLOTS),
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            alloc_valid,
   input  logic                            commit_valid,
   input  logic [SEQ_W-1:0]                commit_seq,
   input  logic                            squash_valid,
   input  logic [SEQ_W-1:0]                squash_seq,
   input  logic [SLOTS-1:0][SEQ_W-1:0]     slot_seq,
   output logic [IDX_W-1:0]                head,
   output logic [IDX_W-1:0]                tail,
   output logic [CNT_W-1:0]                count,
   output logic                            full,
   output logic                            alloc_fire,
   output logic                            err_full,
   output logic                            err_empty
);

   logic [CNT_W-1:0] commit_run;
   logic [CNT_W-1:0] squash_run;
   logic             commit_fire;

   // length of the retirable run starting at the head
   always_comb begin
      logic             stop;
      logic [IDX_W-1:0] pos;
      commit_run = '0;
      stop       = 1'b0;
      for (int unsigned k = 0; k < DEPTH; k++) begin
         pos = IDX_W'(ring_add(32'(head), k, SLOTS));
         if (!stop && (CNT_W'(k) < count) && (slot_seq[pos] <= commit_seq))
            commit_run = commit_run + 1'b1;
         else
            stop = 1'b1;
      end
   end

   // length of the cancelled run walking back from tail-1
   always_comb begin
      logic             stop;
      logic [IDX_W-1:0] pos;
      squash_run = '0;
      stop       = 1'b0;
      for (int unsigned k = 0; k < DEPTH; k++) begin
         pos = IDX_W'(ring_sub(32'(tail), k + 1, SLOTS));
         if (!stop && (CNT_W'(k) < count) && (slot_seq[pos] > squash_seq))
            squash_run = squash_run + 1'b1;
         else
            stop = 1'b1;
      end
   end

   assign full        = (count == CNT_W'(DEPTH));
   assign alloc_fire  = alloc_valid && !squash_valid && !full;
   assign commit_fire = commit_valid && !squash_valid && (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head      <= '0;
         tail      <= '0;
         count     <= '0;
         err_full  <= 1'b0;
         err_empty <= 1'b0;
      end else begin
         err_full  <= alloc_valid && !squash_valid && full;
         err_empty <= commit_valid && !squash_valid && (count == '0);
         if (squash_valid) begin
            tail  <= IDX_W'(ring_sub(32'(tail), 32'(squash_run), SLOTS));
            count <= count - squash_run;
         end else begin
            if (commit_fire)
               head <= IDX_W'(ring_add(32'(head), 32'(commit_run), SLOTS));
            if (alloc_fire)
               tail <= IDX_W'(ring_add(32'(tail), 1, SLOTS));
            count <= count - (commit_fire ? commit_run : '0) + CNT_W'(alloc_fire);
         end
      end
   end

endmodule

// File: rtl/lq_slot_file.sv
module lq_slot_file #(
   parameter int SLOTS  = 5,
   parameter int IDX_W  = 3,
   parameter int SEQ_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          alloc_fire,
   input  logic [IDX_W-1:0]              alloc_idx,
   input  logic [SEQ_W-1:0]              alloc_seq,
   input  logic                          upd_valid,
   input  logic [IDX_W-1:0]              upd_idx,
   input  logic [ADDR_W-1:0]             upd_addr,
   output logic [SLOTS-1:0][SEQ_W-1:0]   slot_seq,
   output logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr,
   output logic [SLOTS-1:0]              slot_exec
);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_seq[s]  <= '0;
            slot_addr[s] <= '0;
            slot_exec[s] <= 1'b0;
         end else if (alloc_fire && (alloc_idx == IDX_W'(s))) begin
            // a fresh load has no address yet: mark it unexecuted
            slot_seq[s]  <= alloc_seq;
            slot_exec[s] <= 1'b0;
         end else if (upd_valid && (upd_idx == IDX_W'(s))) begin
            slot_addr[s] <= upd_addr;
            slot_exec[s] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/lq_order_scan.sv
module lq_order_scan
   import lq_pkg::*;
#(
   parameter int SLOTS  = 5,
   parameter int IDX_W  = 3,
   parameter int SEQ_W  = 8,
   parameter int ADDR_W = 16,
   parameter int SHIFT  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          chk_valid,
   input  logic [IDX_W-1:0]              chk_lq_idx,
   input  logic [ADDR_W-1:0]             chk_addr,
   input  logic [IDX_W-1:0]              tail,
   input  logic [SLOTS-1:0][SEQ_W-1:0]   slot_seq,
   input  logic [SLOTS-1:0][ADDR_W-1:0]  slot_addr,
   input  logic [SLOTS-1:0]              slot_exec,
   input  logic                          viol_read,
   output logic                          chk_busy,
   output logic                          chk_done,
   output logic                          chk_hit,
   output logic [IDX_W-1:0]              chk_hit_idx,
   output logic                          viol_pending,
   output logic [IDX_W-1:0]              viol_idx,
   output logic [SEQ_W-1:0]              viol_seq
);

   scan_state_e      state;
   logic [IDX_W-1:0] ptr;
   logic [ADDR_W-1:0] key_q;
   logic [SLOTS-1:0] match_vec;

   // per-slot coarse match; exact compare when no shift is asked for
   for (genvar s = 0; s < SLOTS; s++) begin : g_match
      if (SHIFT == 0) begin : g_exact
         assign match_vec[s] = slot_exec[s] && (slot_addr[s] == key_q);
      end else begin : g_coarse
         assign match_vec[s] = slot_exec[s] && ((slot_addr[s] >> SHIFT) == (key_q >> SHIFT));
      end
   end

   assign chk_busy = (state != SCAN_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= SCAN_IDLE;
         ptr          <= '0;
         key_q        <= '0;
         chk_done     <= 1'b0;
         chk_hit      <= 1'b0;
         chk_hit_idx  <= '0;
         viol_pending <= 1'b0;
         viol_idx     <= '0;
         viol_seq     <= '0;
      end else begin
         chk_done <= 1'b0;
         chk_hit  <= 1'b0;
         if (viol_read)
            viol_pending <= 1'b0;
         case (state)
            SCAN_IDLE: begin
               if (chk_valid) begin
                  if (viol_pending) begin
                     state <= SCAN_SKIP;
                  end else begin
                     ptr   <= chk_lq_idx;
                     key_q <= chk_addr;
                     state <= SCAN_WALK;
                  end
               end
            end
            SCAN_SKIP: begin
               chk_done <= 1'b1;
               state    <= SCAN_IDLE;
            end
            SCAN_WALK: begin
               if (ptr == tail) begin
                  chk_done <= 1'b1;
                  state    <= SCAN_IDLE;
               end else if (match_vec[ptr]) begin
                  chk_done     <= 1'b1;
                  chk_hit      <= 1'b1;
                  chk_hit_idx  <= ptr;
                  viol_pending <= 1'b1;
                  viol_idx     <= ptr;
                  viol_seq     <= slot_seq[ptr];
                  state        <= SCAN_IDLE;
               end else begin
                  ptr <= (ptr == IDX_W'(SLOTS - 1)) ? '0 : ptr + 1'b1;
               end
            end
            default: state <= SCAN_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lq_order_unit.sv
module lq_order_unit
   import lq_pkg::*;
#(
   parameter int DEPTH    = 4,
   parameter int SEQ_W    = 8,
   parameter int ADDR_W   = 16,
   parameter int SHIFT    = 8,
   parameter int SQ_IDX_W = 3,
   localparam int SLOTS   = DEPTH + 1,
   localparam int IDX_W   = $clog2(SLOTS),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  alloc_valid,
   input  logic [SEQ_W-1:0]      alloc_seq,
   input  logic [SQ_IDX_W-1:0]   alloc_sq_tail,
   input  logic                  alloc_sq_empty,
   output logic [IDX_W-1:0]      alloc_lq_idx,
   output logic [SQ_IDX_W:0]     alloc_sq_ref,
   input  logic                  upd_valid,
   input  logic [IDX_W-1:0]      upd_idx,
   input  logic [ADDR_W-1:0]     upd_addr,
   input  logic                  chk_valid,
   input  logic [IDX_W-1:0]      chk_lq_idx,
   input  logic [ADDR_W-1:0]     chk_addr,
   output logic                  chk_busy,
   output logic                  chk_done,
   output logic                  chk_hit,
   output logic [IDX_W-1:0]      chk_hit_idx,
   input  logic                  commit_valid,
   input  logic [SEQ_W-1:0]      commit_seq,
   input  logic                  squash_valid,
   input  logic [SEQ_W-1:0]      squash_seq,
   input  logic                  blk_set,
   input  logic [SEQ_W-1:0]      blk_seq,
   output logic                  blocked,
   output logic                  viol_pending,
   output logic [IDX_W-1:0]      viol_idx,
   output logic [SEQ_W-1:0]      viol_seq,
   input  logic                  viol_read,
   output logic [CNT_W-1:0]      count,
   output logic                  full,
   output logic                  err_full,
   output logic                  err_empty
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("lq_order_unit: DEPTH must be at least 2");
   end
   if (SHIFT >= ADDR_W) begin : g_bad_shift
      $error("lq_order_unit: SHIFT must be below ADDR_W");
   end
   if (SEQ_W < 2 || SQ_IDX_W < 1) begin : g_bad_width
      $error("lq_order_unit: SEQ_W and SQ_IDX_W too small");
   end

   logic [IDX_W-1:0]               head;
   logic [IDX_W-1:0]               tail;
   logic                           alloc_fire;
   logic [SLOTS-1:0][SEQ_W-1:0]    slot_seq;
   logic [SLOTS-1:0][ADDR_W-1:0]   slot_addr;
   logic [SLOTS-1:0]               slot_exec;
   logic [SEQ_W-1:0]               blk_seq_q;

   assign alloc_lq_idx = tail;
   assign alloc_sq_ref = alloc_sq_empty ? '1 : {1'b0, alloc_sq_tail};

   lq_ring_ctrl #(
      .DEPTH (DEPTH),
      .SEQ_W (SEQ_W),
      .SLOTS (SLOTS),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) i_ring (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_valid  (alloc_valid),
      .commit_valid (commit_valid),
      .commit_seq   (commit_seq),
      .squash_valid (squash_valid),
      .squash_seq   (squash_seq),
      .slot_seq     (slot_seq),
      .head         (head),
      .tail         (tail),
      .count        (count),
      .full         (full),
      .alloc_fire   (alloc_fire),
      .err_full     (err_full),
      .err_empty    (err_empty)
   );

   lq_slot_file #(
      .SLOTS  (SLOTS),
      .IDX_W  (IDX_W),
      .SEQ_W  (SEQ_W),
      .ADDR_W (ADDR_W)
   ) i_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .alloc_idx  (tail),
      .alloc_seq  (alloc_seq),
      .upd_valid  (upd_valid),
      .upd_idx    (upd_idx),
      .upd_addr   (upd_addr),
      .slot_seq   (slot_seq),
      .slot_addr  (slot_addr),
      .slot_exec  (slot_exec)
   );

   lq_order_scan #(
      .SLOTS  (SLOTS),
      .IDX_W  (IDX_W),
      .SEQ_W  (SEQ_W),
      .ADDR_W (ADDR_W),
      .SHIFT  (SHIFT)
   ) i_scan (
      .clk          (clk),
      .rst_n        (rst_n),
      .chk_valid    (chk_valid),
      .chk_lq_idx   (chk_lq_idx),
      .chk_addr     (chk_addr),
      .tail         (tail),
      .slot_seq     (slot_seq),
      .slot_addr    (slot_addr),
      .slot_exec    (slot_exec),
      .viol_read    (viol_read),
      .chk_busy     (chk_busy),
      .chk_done     (chk_done),
      .chk_hit      (chk_hit),
      .chk_hit_idx  (chk_hit_idx),
      .viol_pending (viol_pending),
      .viol_idx     (viol_idx),
      .viol_seq     (viol_seq)
   );

   // blocked-load record: a squash older than the blocked load drops it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blocked   <= 1'b0;
         blk_seq_q <= '0;
      end else if (blk_set) begin
         blocked   <= 1'b1;
         blk_seq_q <= blk_seq;
      end else if (squash_valid && blocked && (squash_seq < blk_seq_q)) begin
         blocked   <= 1'b0;
         blk_seq_q <= '0;
      end
   end

   // head is kept for the ring walk; reference it here so it is not dangling
   logic head_unused;
   assign head_unused = ^head;

endmodule

// File: rtl/lq_order_unit_chk.sv
module lq_order_unit_chk #(
   parameter int DEPTH = 4,
   parameter int SEQ_W = 8,
   parameter int IDX_W = 3,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             commit_valid,
   input logic             squash_valid,
   input logic [SEQ_W-1:0] squash_seq,
   input logic             blk_set,
   input logic [SEQ_W-1:0] blk_seq_q,
   input logic             blocked,
   input logic [CNT_W-1:0] count,
   input logic             full,
   input logic             err_full,
   input logic             err_empty,
   input logic             chk_done,
   input logic             viol_pending,
   input logic [IDX_W-1:0] viol_idx,
   input logic             viol_read
);

   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R1

   AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid && full && !squash_valid && !commit_valid
      |=> (count == $past(count)) && err_full); // R2

   AST_EMPTY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid && (count == '0) && !squash_valid && !alloc_valid
      |=> (count == '0) && err_empty); // R4

   AST_SQUASH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> count <= $past(count)); // R5

   AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> !err_full && !err_empty); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |=> !chk_done); // R8

   AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pending && !viol_read |=> viol_pending && $stable(viol_idx)); // R10

   AST_VIOL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pending && viol_read |=> !viol_pending); // R10

   AST_BLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid && blocked && !blk_set && (squash_seq < blk_seq_q) |=> !blocked); // R12

endmodule

bind lq_order_unit lq_order_unit_chk #(
   .DEPTH (DEPTH),
   .SEQ_W (SEQ_W),
   .IDX_W (IDX_W),
   .CNT_W (CNT_W)
) i_lq_order_unit_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_valid  (alloc_valid),
   .commit_valid (commit_valid),
   .squash_valid (squash_valid),
   .squash_seq   (squash_seq),
   .blk_set      (blk_set),
   .blk_seq_q    (blk_seq_q),
   .blocked      (blocked),
   .count        (count),
   .full         (full),
   .err_full     (err_full),
   .err_empty    (err_empty),
   .chk_done     (chk_done),
   .viol_pending (viol_pending),
   .viol_idx     (viol_idx),
   .viol_read    (viol_read)
);

// File: tb/test_lq_order_unit.sv
module test_lq_order_unit;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 4;
   localparam int SLOTS  = DEPTH + 1;
   localparam int SEQ_W  = 8;
   localparam int ADDR_W = 16;
   localparam int SHIFT  = 8;
   localparam int SQW    = 3;
   localparam int IDX_W  = 3;
   localparam int CNT_W  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 0, alloc_sq_empty = 0, upd_valid = 0, chk_valid = 0;
   logic commit_valid = 0, squash_valid = 0, blk_set = 0, viol_read = 0;
   logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0, blk_seq = '0;
   logic [SQW-1:0] alloc_sq_tail = '0;
   logic [IDX_W-1:0] upd_idx = '0, chk_lq_idx = '0;
   logic [ADDR_W-1:0] upd_addr = '0, chk_addr = '0;
   logic [IDX_W-1:0] alloc_lq_idx, chk_hit_idx, viol_idx;
   logic [SQW:0] alloc_sq_ref;
   logic chk_busy, chk_done, chk_hit, blocked, viol_pending, full, err_full, err_empty;
   logic [SEQ_W-1:0] viol_seq;
   logic [CNT_W-1:0] count;

   int n_checks = 0;
   int n_fail = 0;

   // requirement-level model of the ring
   int  m_head = 0, m_tail = 0, m_cnt = 0;
   int  m_seq[SLOTS];
   int  m_addr[SLOTS];
   bit  m_exec[SLOTS];
   bit  m_pend = 0;
   int  m_vidx = 0, m_vseq = 0;
   bit  m_blk = 0;
   int  m_bseq = 0;

   lq_order_unit #(
      .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SHIFT(SHIFT), .SQ_IDX_W(SQW)
   ) i_lq_order_unit (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_sq_tail(alloc_sq_tail),
      .alloc_sq_empty(alloc_sq_empty), .alloc_lq_idx(alloc_lq_idx), .alloc_sq_ref(alloc_sq_ref),
      .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_addr(upd_addr),
      .chk_valid(chk_valid), .chk_lq_idx(chk_lq_idx), .chk_addr(chk_addr),
      .chk_busy(chk_busy), .chk_done(chk_done), .chk_hit(chk_hit), .chk_hit_idx(chk_hit_idx),
      .commit_valid(commit_valid), .commit_seq(commit_seq),
      .squash_valid(squash_valid), .squash_seq(squash_seq),
      .blk_set(blk_set), .blk_seq(blk_seq), .blocked(blocked),
      .viol_pending(viol_pending), .viol_idx(viol_idx), .viol_seq(viol_seq), .viol_read(viol_read),
      .count(count), .full(full), .err_full(err_full), .err_empty(err_empty)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic do_alloc(input int seq, input int sqt, input bit sqe);
      alloc_valid = 1; alloc_seq = SEQ_W'(seq); alloc_sq_tail = SQW'(sqt); alloc_sq_empty = sqe;
      #1;
      if (m_cnt < DEPTH) check("R1", "alloc slot", int'(alloc_lq_idx), m_tail);
      check("R7", "store-queue reference", int'(alloc_sq_ref), sqe ? 15 : sqt);
      tick();
      alloc_valid = 0;
      if (m_cnt < DEPTH) begin
         m_seq[m_tail] = seq; m_exec[m_tail] = 0;
         m_tail = (m_tail + 1) % SLOTS; m_cnt++;
         check("R2", "no reject flag", int'(err_full), 0);
      end else begin
         check("R2", "reject flag when full", int'(err_full), 1);
      end
      check("R1", "count after alloc", int'(count), m_cnt);
      check("R1", "full flag", int'(full), (m_cnt == DEPTH) ? 1 : 0);
   endtask

   task automatic do_commit(input int cseq);
      bit was_empty;
      was_empty = (m_cnt == 0);
      commit_valid = 1; commit_seq = SEQ_W'(cseq);
      tick();
      commit_valid = 0;
      while (m_cnt > 0 && m_seq[m_head] <= cseq) begin
         m_head = (m_head + 1) % SLOTS; m_cnt--;
      end
      check("R3", "count after commit", int'(count), m_cnt);
      check("R4", "empty commit flag", int'(err_empty), was_empty ? 1 : 0);
   endtask

   task automatic do_squash(input int s, input bit with_alloc, input bit with_commit);
      squash_valid = 1; squash_seq = SEQ_W'(s);
      alloc_valid = with_alloc; alloc_seq = 8'd99; alloc_sq_empty = 1;
      commit_valid = with_commit; commit_seq = 8'd255;
      tick();
      squash_valid = 0; alloc_valid = 0; commit_valid = 0;
      while (m_cnt > 0 && m_seq[(m_tail + SLOTS - 1) % SLOTS] > s) begin
         m_tail = (m_tail + SLOTS - 1) % SLOTS; m_cnt--;
      end
      if (m_blk && s < m_bseq) m_blk = 0;
      check("R5", "count after squash", int'(count), m_cnt);
      check("R6", "no error flags on squash", int'(err_full) + int'(err_empty), 0);
      check("R12", "blocked after squash", int'(blocked), int'(m_blk));
   endtask

   task automatic do_update(input int idx, input int addr);
      upd_valid = 1; upd_idx = IDX_W'(idx); upd_addr = ADDR_W'(addr);
      tick();
      upd_valid = 0;
      m_addr[idx] = addr; m_exec[idx] = 1;
   endtask

   task automatic do_read();
      viol_read = 1;
      tick();
      viol_read = 0;
      m_pend = 0;
      check("R10", "pending cleared by read", int'(viol_pending), 0);
   endtask

   task automatic do_check(input int start, input int addr);
      int  p, j, lat, exp_lat, exp_idx;
      bit  exp_hit;
      exp_hit = 0; exp_idx = 0;
      if (m_pend) begin
         exp_lat = 1;
      end else begin
         p = start; j = 0;
         while (p != m_tail && !exp_hit) begin
            if (m_exec[p] && ((m_addr[p] >> SHIFT) == (addr >> SHIFT))) begin
               exp_hit = 1; exp_idx = p;
            end else begin
               p = (p + 1) % SLOTS; j++;
            end
         end
         exp_lat = j + 1;
      end
      chk_valid = 1; chk_lq_idx = IDX_W'(start); chk_addr = ADDR_W'(addr);
      tick();
      chk_valid = 0;
      lat = 0;
      do begin
         tick();
         lat++;
      end while (!chk_done && lat < 20);
      if (m_pend) begin
         check("R11", "skipped check hit", int'(chk_hit), 0);
         check("R11", "skipped check latency", lat, exp_lat);
         check("R11", "violation kept", int'(viol_idx), m_vidx);
      end else begin
         check("R8", "hit flag", int'(chk_hit), int'(exp_hit));
         check("R8", "scan latency", lat, exp_lat);
         if (exp_hit) begin
            check("R8", "hit slot", int'(chk_hit_idx), exp_idx);
            m_pend = 1; m_vidx = exp_idx; m_vseq = m_seq[exp_idx];
         end
      end
      check("R10", "pending flag", int'(viol_pending), int'(m_pend));
      if (m_pend) begin
         check("R10", "violation slot", int'(viol_idx), m_vidx);
         check("R10", "violation seq", int'(viol_seq), m_vseq);
      end
   endtask

   task automatic fill4(input int base);
      for (int k = 0; k < DEPTH; k++) do_alloc(base + 10 * k, k + 1, 1'b0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fail++;
      $display("FAIL R8 watchdog expired: got 0 expected 1");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < SLOTS; i++) begin m_seq[i] = 0; m_addr[i] = 0; m_exec[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      // reset state
      check("R1", "reset count", int'(count), 0);
      check("R1", "reset full", int'(full), 0);
      check("R8", "reset busy", int'(chk_busy), 0);
      check("R10", "reset pending", int'(viol_pending), 0);
      check("R12", "reset blocked", int'(blocked), 0);

      // fill, reject when full, store-queue reference both ways
      do_alloc(10, 0, 1'b1);
      do_alloc(20, 2, 1'b0);
      do_alloc(30, 3, 1'b0);
      do_alloc(40, 5, 1'b0);
      do_alloc(45, 6, 1'b0);

      // commit partially, nothing, then wrap the tail
      do_commit(25);
      do_commit(5);
      do_alloc(50, 1, 1'b0);
      do_alloc(60, 1, 1'b1);
      do_squash(45, 1'b0, 1'b0);
      do_alloc(55, 0, 1'b0);

      // squash collides with alloc and commit
      do_squash(200, 1'b1, 1'b0);
      do_squash(200, 1'b0, 1'b1);
      do_alloc(70, 0, 1'b0);

      // drain and commit on empty
      do_commit(255);
      do_commit(255);

      // squash boundary sweep over a full ring
      for (int s = 5; s <= 45; s += 5) begin
         fill4(10);
         do_squash(s, 1'b0, 1'b0);
         do_commit(255);
      end

      // ordering check sweep; the first slot holds a stale address (R9)
      do_update(m_tail, 16'h0050);
      fill4(10);
      do_update((m_head + 1) % SLOTS, 16'h1234);
      do_update((m_head + 2) % SLOTS, 16'h12FF);
      do_update((m_head + 3) % SLOTS, 16'h5600);
      for (int off = 0; off < DEPTH; off++) begin
         for (int a = 0; a < 4; a++) begin
            int addr;
            addr = (a == 0) ? 16'h1200 : (a == 1) ? 16'h5611 : (a == 2) ? 16'h9900 : 16'h0011;
            do_check((m_head + off) % SLOTS, addr);
            if (m_pend) do_read();
         end
      end

      // check with an unread violation is skipped
      do_check((m_head + 1) % SLOTS, 16'h1200);
      do_check((m_head + 3) % SLOTS, 16'h5600);
      do_read();
      do_check((m_head + 3) % SLOTS, 16'h5600);
      do_read();

      // blocked-load record
      blk_set = 1; blk_seq = 8'd30;
      tick();
      blk_set = 0; m_blk = 1; m_bseq = 30;
      check("R12", "blocked set", int'(blocked), 1);
      do_squash(35, 1'b0, 1'b0);
      do_squash(30, 1'b0, 1'b0);
      do_squash(25, 1'b0, 1'b0);

      summary();
      $finish;
   end

endmodule